// File: doc/BRIEF.md
# Scan Group Capture Clock Gate

This block drives the clocks of a scan chain whose cells are split into several mutually exclusive groups. While the tester shifts data through the chain, every group runs on the test clock. In the single capture cycle, each group is clocked only if its bit is set in a control word. A group whose bit is clear gets no capture edge and keeps the value shifted into it. Fewer cells toggle in that cycle, so the capture power peak drops.

The control word depends on the vector being captured. A saturating pattern counter advances at the end of each shift window and gives the index of the vector just loaded. A programmable table of index ranges maps that index to a cluster. Each cluster owns one word with a bit per group. The cluster assignments are worked out offline and loaded through two simple write ports. Cells that must capture on every vector belong to no group and use the always-on clock output.

Top module: `scan_gate_ctrl`

## Requirements
- R1: While `gate_en` is 0, every `grp_clk` bit follows `tclk` edge for edge. This holds during reset, during shift and in idle cycles.
- R2: While `gate_en` is 1, `grp_clk[g]` pulses on a rising `tclk` edge exactly when bit g of the selected cluster word is 1. Bit g controls group g.
- R3: `core_clk` follows `tclk` at all times, whatever the values of `gate_en` and the control word.
- R4: The pattern counter resets to 0 and advances by one on each falling edge of `scan_en`. The vector index used for a capture is the number of shift windows completed before the latest one, so the first vector after reset has index 0.
- R5: The pattern counter saturates at 2^CNT_W-1. Every later vector uses that index.
- R6: The range slots are searched from slot 0 upward. The first valid slot whose limit is greater than or equal to the vector index supplies the cluster.
- R7: An index that matches no slot selects cluster 0. The word of cluster 0 is all ones, and writes that address cluster 0 have no effect.
- R8: A slot written with `map_wr_valid`=0 never matches, whatever its limit and cluster.
- R9: After reset, every slot is invalid and every cluster word is all ones, so every group captures.
- R10: The selected word is registered on every `tclk` edge while `gate_en` is 0 and is frozen while `gate_en` is 1. A word write made during capture affects only later vectors. At least two `tclk` edges with `scan_en` and `gate_en` both 0 must come between the end of shift and the rise of `gate_en`.
- R11: Each group enable is held in a latch that is transparent while `tclk` is low. The gated clock is `tclk` AND the latched enable, so no group sees a shortened pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tclk | input | 1 | Free-running test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Shift window indicator from the tester |
| gate_en | input | 1 | Capture gating indicator from the tester |
| map_wr_en | input | 1 | Write strobe for a range slot |
| map_wr_slot | input | SLOT_W | Range slot to write |
| map_wr_valid | input | 1 | Valid flag for the written slot |
| map_wr_limit | input | CNT_W | Highest vector index covered by the slot |
| map_wr_cluster | input | CL_W | Cluster selected by the slot |
| word_wr_en | input | 1 | Write strobe for a cluster word |
| word_wr_cluster | input | CL_W | Cluster whose word is written |
| word_wr_data | input | NUM_GROUPS | New control word, one bit per group |
| grp_en | output | NUM_GROUPS | Latched clock enable per group |
| grp_clk | output | NUM_GROUPS | Gated clock per group |
| core_clk | output | 1 | Ungated clock for cells outside every group |

## Verification
The bench counts rising edges on each group clock and on the always-on clock. It does this separately for every shift window and for every capture cycle. Shift windows of random length show that gating never takes a shift edge. Capture cycles use words drawn at random plus an all-zero word, so each bit must reach its own group. The vector sequence walks the index across the boundaries of ranges listed in ascending order, through an invalid slot, past the last range to cluster 0, and into counter saturation. This separates a wrong search order, a slot that should be ignored, a wrong counter offset and a missing saturation. A word rewritten during a capture cycle checks that the value frozen at the start of capture is the one applied.

// File: rtl/sgcg_pkg.sv
package sgcg_pkg;

  localparam int unsigned DEF_GROUPS   = 15;
  localparam int unsigned DEF_CLUSTERS = 16;
  localparam int unsigned DEF_SLOTS    = 8;
  localparam int unsigned DEF_CNT_W    = 10;

  function automatic int unsigned width_of(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/sgcg_pattern_ctr.sv
module sgcg_pattern_ctr #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_en,
  output logic [CNT_W-1:0] loads,
  output logic [CNT_W-1:0] vec_idx,
  output logic             se_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             shift_done;
  logic [CNT_W-1:0] loads_d;
  logic [CNT_W-1:0] vec_idx_d;

  always_comb begin
    shift_done = se_q & ~scan_en;
    loads_d    = loads;
    vec_idx_d  = vec_idx;
    if (shift_done) begin
      vec_idx_d = loads;
      if (loads != CNT_MAX) begin
        loads_d = loads + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      se_q    <= 1'b0;
      loads   <= '0;
      vec_idx <= '0;
    end else begin
      se_q    <= scan_en;
      loads   <= loads_d;
      vec_idx <= vec_idx_d;
    end
  end

endmodule

// File: rtl/sgcg_cluster_map.sv
module sgcg_cluster_map #(
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned CL_W      = 4,
  parameter int unsigned SLOT_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              wr_valid,
  input  logic [CNT_W-1:0]  wr_limit,
  input  logic [CL_W-1:0]   wr_cluster,
  input  logic [CNT_W-1:0]  vec_idx,
  output logic [CL_W-1:0]   cluster
);

  logic [NUM_SLOTS-1:0] slot_valid;
  logic [CNT_W-1:0]     slot_limit   [NUM_SLOTS];
  logic [CL_W-1:0]      slot_cluster [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slot_hit;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic wr_this;
    assign wr_this     = wr_en && (wr_slot == SLOT_W'(s));
    assign slot_hit[s] = slot_valid[s] && (vec_idx <= slot_limit[s]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_valid[s]   <= 1'b0;
        slot_limit[s]   <= '0;
        slot_cluster[s] <= '0;
      end else if (wr_this) begin
        slot_valid[s]   <= wr_valid;
        slot_limit[s]   <= wr_limit;
        slot_cluster[s] <= wr_cluster;
      end
    end
  end

  // Lowest-numbered hitting slot wins: scan downward so it is applied last.
  always_comb begin
    cluster = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (slot_hit[s]) begin
        cluster = slot_cluster[s];
      end
    end
  end

endmodule

// File: rtl/sgcg_word_table.sv
module sgcg_word_table #(
  parameter int unsigned NUM_GROUPS   = 15,
  parameter int unsigned NUM_CLUSTERS = 16,
  parameter int unsigned CL_W         = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [CL_W-1:0]       wr_cluster,
  input  logic [NUM_GROUPS-1:0] wr_data,
  input  logic [CL_W-1:0]       sel_cluster,
  input  logic                  hold,
  output logic [NUM_GROUPS-1:0] word_q
);

  logic [NUM_GROUPS-1:0] words [NUM_CLUSTERS];
  logic [NUM_GROUPS-1:0] sel_word;
  logic [NUM_GROUPS-1:0] word_d;

  for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : g_cl
    if (c == 0) begin : g_fixed
      assign words[c] = '1;
    end else begin : g_prog
      logic wr_this;
      assign wr_this = wr_en && (wr_cluster == CL_W'(c));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          words[c] <= '1;
        end else if (wr_this) begin
          words[c] <= wr_data;
        end
      end
    end
  end

  always_comb begin
    sel_word = '1;
    if (32'(sel_cluster) < NUM_CLUSTERS) begin
      sel_word = words[sel_cluster];
    end
    word_d = hold ? word_q : sel_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '1;
    end else begin
      word_q <= word_d;
    end
  end

endmodule

// File: rtl/sgcg_clk_gate.sv
module sgcg_clk_gate #(
  parameter int unsigned NUM_GROUPS = 15
) (
  input  logic                  clk,
  input  logic [NUM_GROUPS-1:0] en_d,
  output logic [NUM_GROUPS-1:0] en_lat,
  output logic [NUM_GROUPS-1:0] gclk
);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_cell
    always_latch begin
      if (!clk) begin
        en_lat[g] = en_d[g];
      end
    end
    assign gclk[g] = clk & en_lat[g];
  end

endmodule

// File: rtl/scan_gate_ctrl.sv
module scan_gate_ctrl
  import sgcg_pkg::*;
#(
  parameter int unsigned NUM_GROUPS   = DEF_GROUPS,
  parameter int unsigned NUM_CLUSTERS = DEF_CLUSTERS,
  parameter int unsigned NUM_SLOTS    = DEF_SLOTS,
  parameter int unsigned CNT_W        = DEF_CNT_W,
  localparam int unsigned CL_W        = width_of(NUM_CLUSTERS),
  localparam int unsigned SLOT_W      = width_of(NUM_SLOTS)
) (
  input  logic                  tclk,
  input  logic                  rst_n,
  input  logic                  scan_en,
  input  logic                  gate_en,
  input  logic                  map_wr_en,
  input  logic [SLOT_W-1:0]     map_wr_slot,
  input  logic                  map_wr_valid,
  input  logic [CNT_W-1:0]      map_wr_limit,
  input  logic [CL_W-1:0]       map_wr_cluster,
  input  logic                  word_wr_en,
  input  logic [CL_W-1:0]       word_wr_cluster,
  input  logic [NUM_GROUPS-1:0] word_wr_data,
  output logic [NUM_GROUPS-1:0] grp_en,
  output logic [NUM_GROUPS-1:0] grp_clk,
  output logic                  core_clk
);

  logic [CNT_W-1:0]      loads;
  logic [CNT_W-1:0]      vec_idx;
  logic                  se_q;
  logic [CL_W-1:0]       sel_cluster;
  logic [NUM_GROUPS-1:0] word_q;
  logic [NUM_GROUPS-1:0] en_d;

  sgcg_pattern_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (tclk),
    .rst_n   (rst_n),
    .scan_en (scan_en),
    .loads   (loads),
    .vec_idx (vec_idx),
    .se_q    (se_q)
  );

  sgcg_cluster_map #(
    .CNT_W(CNT_W), .NUM_SLOTS(NUM_SLOTS), .CL_W(CL_W), .SLOT_W(SLOT_W)
  ) u_map (
    .clk        (tclk),
    .rst_n      (rst_n),
    .wr_en      (map_wr_en),
    .wr_slot    (map_wr_slot),
    .wr_valid   (map_wr_valid),
    .wr_limit   (map_wr_limit),
    .wr_cluster (map_wr_cluster),
    .vec_idx    (vec_idx),
    .cluster    (sel_cluster)
  );

  sgcg_word_table #(
    .NUM_GROUPS(NUM_GROUPS), .NUM_CLUSTERS(NUM_CLUSTERS), .CL_W(CL_W)
  ) u_words (
    .clk         (tclk),
    .rst_n       (rst_n),
    .wr_en       (word_wr_en),
    .wr_cluster  (word_wr_cluster),
    .wr_data     (word_wr_data),
    .sel_cluster (sel_cluster),
    .hold        (gate_en),
    .word_q      (word_q)
  );

  assign en_d = gate_en ? word_q : '1;

  sgcg_clk_gate #(.NUM_GROUPS(NUM_GROUPS)) u_gate (
    .clk    (tclk),
    .en_d   (en_d),
    .en_lat (grp_en),
    .gclk   (grp_clk)
  );

  assign core_clk = tclk;

endmodule

// File: rtl/sgcg_checker.sv
module sgcg_checker #(
  parameter int unsigned NUM_GROUPS = 15,
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned CL_W       = 4
) (
  input logic                  tclk,
  input logic                  rst_n,
  input logic                  scan_en,
  input logic                  gate_en,
  input logic                  se_q,
  input logic [CNT_W-1:0]      loads,
  input logic [CNT_W-1:0]      vec_idx,
  input logic [CL_W-1:0]       sel_cluster,
  input logic [NUM_GROUPS-1:0] word_q,
  input logic [NUM_GROUPS-1:0] grp_en
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R1
  all_open_chk: assert property (@(posedge tclk) disable iff (!rst_n)
    !gate_en |-> grp_en == '1);

  // R2
  word_applied_chk: assert property (@(posedge tclk) disable iff (!rst_n)
    gate_en |-> grp_en == word_q);

  // R10
  word_frozen_chk: assert property (@(posedge tclk) disable iff (!rst_n)
    gate_en |=> $stable(word_q));

  // R5
  cnt_sat_chk: assert property (@(posedge tclk) disable iff (!rst_n)
    loads == CNT_MAX |=> loads == CNT_MAX);

  // R4
  idx_take_chk: assert property (@(posedge tclk) disable iff (!rst_n)
    (se_q && !scan_en) |=> vec_idx == $past(loads));

  // R7
  default_word_chk: assert property (@(posedge tclk) disable iff (!rst_n)
    (sel_cluster == '0 && !gate_en) |=> word_q == '1);

endmodule

bind scan_gate_ctrl sgcg_checker #(
  .NUM_GROUPS(NUM_GROUPS), .CNT_W(CNT_W), .CL_W(CL_W)
) u_chk (
  .tclk        (tclk),
  .rst_n       (rst_n),
  .scan_en     (scan_en),
  .gate_en     (gate_en),
  .se_q        (se_q),
  .loads       (loads),
  .vec_idx     (vec_idx),
  .sel_cluster (sel_cluster),
  .word_q      (word_q),
  .grp_en      (grp_en)
);

// File: tb/scan_gate_ctrl_tb.sv
module scan_gate_ctrl_tb;

  localparam int unsigned NG   = 15;
  localparam int unsigned NC   = 16;
  localparam int unsigned NS   = 4;
  localparam int unsigned CW   = 4;
  localparam int unsigned CLW  = 4;
  localparam int unsigned SLW  = 2;
  localparam int unsigned IMAX = 15;

  logic           tclk = 1'b0;
  logic           rst_n;
  logic           scan_en;
  logic           gate_en;
  logic           map_wr_en;
  logic [SLW-1:0] map_wr_slot;
  logic           map_wr_valid;
  logic [CW-1:0]  map_wr_limit;
  logic [CLW-1:0] map_wr_cluster;
  logic           word_wr_en;
  logic [CLW-1:0] word_wr_cluster;
  logic [NG-1:0]  word_wr_data;
  logic [NG-1:0]  grp_en;
  logic [NG-1:0]  grp_clk;
  logic           core_clk;

  int errors = 0;
  int checks = 0;
  bit counting = 1'b0;
  int ecnt [NG];
  int ccnt;

  // bench model of the programmed tables
  bit            m_valid [NS];
  int            m_limit [NS];
  int            m_clus  [NS];
  logic [NG-1:0] m_word  [NC];

  always #5 tclk = ~tclk;

  scan_gate_ctrl #(
    .NUM_GROUPS(NG), .NUM_CLUSTERS(NC), .NUM_SLOTS(NS), .CNT_W(CW)
  ) u_dut (
    .tclk(tclk), .rst_n(rst_n), .scan_en(scan_en), .gate_en(gate_en),
    .map_wr_en(map_wr_en), .map_wr_slot(map_wr_slot),
    .map_wr_valid(map_wr_valid), .map_wr_limit(map_wr_limit),
    .map_wr_cluster(map_wr_cluster), .word_wr_en(word_wr_en),
    .word_wr_cluster(word_wr_cluster), .word_wr_data(word_wr_data),
    .grp_en(grp_en), .grp_clk(grp_clk), .core_clk(core_clk)
  );

  for (genvar g = 0; g < NG; g++) begin : g_cnt
    always @(posedge grp_clk[g]) if (counting) ecnt[g] = ecnt[g] + 1;
  end
  always @(posedge core_clk) if (counting) ccnt = ccnt + 1;

  function automatic int exp_cluster(input int idx);
    for (int s = 0; s < NS; s++) begin
      if (m_valid[s] && idx <= m_limit[s]) return m_clus[s];
    end
    return 0;
  endfunction

  function automatic string tag_for(input int k, input int idx, input int cl);
    if (k == 0) return "R9";
    if (k > int'(IMAX)) return "R5";
    if (idx >= 10 && idx <= 12) return "R8";
    if (cl == 0) return "R7";
    if (idx <= 2) return "R6";
    if (idx == 7) return "R10";
    return "R2";
  endfunction

  task automatic clear_counts();
    for (int g = 0; g < NG; g++) ecnt[g] = 0;
    ccnt = 0;
  endtask

  function automatic logic [NG-1:0] edges_seen(input int want_each);
    logic [NG-1:0] v;
    for (int g = 0; g < NG; g++) v[g] = (ecnt[g] == want_each);
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_slot(input int s, input bit v, input int lim, input int cl);
    @(negedge tclk);
    map_wr_en = 1'b1; map_wr_slot = SLW'(s); map_wr_valid = v;
    map_wr_limit = CW'(lim); map_wr_cluster = CLW'(cl);
    m_valid[s] = v; m_limit[s] = lim; m_clus[s] = cl;
    @(negedge tclk);
    map_wr_en = 1'b0;
  endtask

  task automatic wr_word(input int cl, input logic [NG-1:0] w);
    @(negedge tclk);
    word_wr_en = 1'b1; word_wr_cluster = CLW'(cl); word_wr_data = w;
    if (cl != 0) m_word[cl] = w;
    @(negedge tclk);
    word_wr_en = 1'b0;
  endtask

  // one vector: shift window, two idle edges, one capture edge
  task automatic run_vector(input int k, input bit rewrite);
    int len;
    int idx;
    int cl;
    logic [NG-1:0] exp_w;
    logic [NG-1:0] got;
    logic [NG-1:0] new_w;
    len = 2 + int'($urandom % 5);
    @(negedge tclk);
    clear_counts();
    scan_en = 1'b1; counting = 1'b1;
    repeat (len) @(posedge tclk);
    @(negedge tclk);
    counting = 1'b0; scan_en = 1'b0;
    // R1 R3: all groups clocked during shift
    check(edges_seen(len) == '1 && ccnt == len, "R1",
          "shift edges", 32'(ecnt[0]), 32'(len));
    idx = (k > int'(IMAX)) ? int'(IMAX) : k;
    cl  = exp_cluster(idx);
    exp_w = m_word[cl];
    repeat (2) @(posedge tclk);
    @(negedge tclk);
    clear_counts();
    gate_en = 1'b1; counting = 1'b1;
    new_w = ~exp_w;
    if (rewrite) begin
      word_wr_en = 1'b1; word_wr_cluster = CLW'(cl); word_wr_data = new_w;
    end
    @(posedge tclk);
    @(negedge tclk);
    gate_en = 1'b0; counting = 1'b0; word_wr_en = 1'b0;
    if (rewrite) m_word[cl] = new_w;
    for (int g = 0; g < NG; g++) got[g] = (ecnt[g] == 1);
    // R2 R4 R11: each group gets one full capture edge iff its bit is set
    check(got == exp_w && edges_seen(0) == ~exp_w, tag_for(k, idx, cl),
          $sformatf("capture word v%0d idx%0d R4", k, idx), 32'(got), 32'(exp_w));
    check(ccnt == 1, "R3", "core clock in capture", 32'(ccnt), 32'd1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int s = 0; s < NS; s++) begin
      m_valid[s] = 1'b0; m_limit[s] = 0; m_clus[s] = 0;
    end
    for (int c = 0; c < NC; c++) m_word[c] = '1;
    rst_n = 1'b0; scan_en = 1'b0; gate_en = 1'b0;
    map_wr_en = 1'b0; map_wr_slot = '0; map_wr_valid = 1'b0;
    map_wr_limit = '0; map_wr_cluster = '0;
    word_wr_en = 1'b0; word_wr_cluster = '0; word_wr_data = '0;
    clear_counts();
    @(negedge tclk);
    counting = 1'b1;
    repeat (3) @(posedge tclk);
    @(negedge tclk);
    counting = 1'b0;
    // R1 R9: clocks pass while in reset
    check(edges_seen(3) == '1, "R9", "edges in reset", 32'(ecnt[0]), 32'd3);
    rst_n = 1'b1;
    repeat (2) @(negedge tclk);

    // vector 0 on reset tables: every group captures (R9)
    run_vector(0, 1'b0);

    // program: ascending ranges, one invalid slot, cluster 0 write attempt
    wr_slot(0, 1'b1, 2, 3);
    wr_slot(1, 1'b1, 5, 1);
    wr_slot(2, 1'b1, 9, 7);
    wr_slot(3, 1'b0, 12, 5);
    wr_word(0, '0);
    wr_word(1, '0);
    wr_word(3, NG'($urandom));
    wr_word(5, NG'($urandom));
    wr_word(7, NG'($urandom));

    for (int k = 1; k < 19; k++) begin
      run_vector(k, k == 7);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule